// File: doc/BRIEF.md
# Audio Sample FIFO Output Port

A processor-side audio output device. Software stores 8-bit offset-binary samples into a 16-entry FIFO through a small register bus. A timer derived from the system clock removes one sample per audio period (8 kHz by default). The removed sample drives a one-bit pulse modulator, which compares it against a free-running 8-bit ramp whose bits are reversed. This spreads the high time of the output across the whole ramp period, and an external low-pass filter turns the bit stream into an analogue level.

Software can feed the device in three ways. It can poll a status word. It can wait for an interrupt that fires when the FIFO drains to half full. It can let a DMA engine respond to a request line that stays high while the fill level is below a programmable watermark. When the FIFO runs dry, the output goes to the mid-scale level 0x80 (silence) and does not repeat the last sample.

Two small state machines carry the control:
- The playback machine has states `PS_SILENT` and `PS_PLAYING`. On a timer strobe it moves from SILENT to PLAYING if the FIFO holds data. On a strobe that finds the FIFO empty, it moves from PLAYING to SILENT.
- The interrupt machine has states `IS_ARMED` and `IS_PENDING`. A drain across the half level moves it from ARMED to PENDING. A software clear with no crossing in the same cycle moves it from PENDING back to ARMED.

Top module: `aud_fifo_out`

## Requirements
- R1: After reset the following hold:
  - occupancy is 0, overflow is 0 and no interrupt is pending, so `irq` is 0;
  - the watermark is 4 and `dma_req` is 1;
  - the playback state is `PS_SILENT`, and the modulator plays the level 0x80;
  - status reads 0x300.
- R2: A bus write to address 0 pushes `bus_wdata[7:0]` into the FIFO.
  - A read of address 1 returns the status word on `bus_rdata` in the cycle after the read strobe.
  - Status bits 4:0 hold the occupancy.
  - Bit 8 is set when occupancy ≤ 8.
  - Bit 9 is set when occupancy < watermark.
  - Bit 10 is the overflow flag.
  - Bit 11 is the interrupt-pending flag.
- R3: Exactly one sample is removed per CLK_HZ/RATE_HZ clock cycles while the FIFO is not empty.
- R4: The FIFO holds 16 entries.
  - A write to a full FIFO with no removal in the same cycle is dropped and sets the sticky overflow bit.
  - A write to address 2 with bit 1 set clears the overflow bit.
  - A write that lands in the same cycle as a removal is accepted even when the FIFO is full.
- R5: The interrupt behaves as follows:
  - It becomes pending when a removal takes occupancy from 9 to 8.
  - It stays pending until a write to address 2 with bit 0 set.
  - A crossing in the same cycle as a clear leaves it pending.
  - A clear with no crossing removes it, and later drains below 8 do not set it again.
- R6: `dma_req` equals (occupancy < watermark).
  - The watermark is read and written at address 3, bits 4:0.
- R7: A timer strobe that finds the FIFO empty switches the output to the level 0x80.
  - At that level `audio_out` toggles on every clock.
- R8: While the held level is V, `audio_out` is high in exactly V cycles out of any 256 consecutive cycles.
- R9: Samples are played in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address: 0 sample, 1 status, 2 control, 3 watermark |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Half-empty interrupt, level, held until cleared |
| dma_req | output | 1 | High while occupancy is below the watermark |
| audio_out | output | 1 | Pulse-modulated one-bit audio |

## Verification
The timer's removal can land in the same clock edge as a software write, and two such collisions matter:
- **Interrupt clear during the crossing.** The bench clears the interrupt in the very edge where a removal takes the FIFO from 9 to 8. It expects the interrupt to remain pending.
- **Push into a full FIFO during a removal.** The bench pushes a sample into a full FIFO in the edge of a removal. It expects the sample to be accepted, occupancy to stay at 16 and no overflow.

To place these writes, the bench first locates a removal edge by reading the status on every cycle. It then counts whole sample periods forward from that edge.

// File: rtl/aud_fifo_pkg.sv
package aud_fifo_pkg;

    typedef enum logic {
        PS_SILENT,
        PS_PLAYING
    } play_state_t;

    typedef enum logic {
        IS_ARMED,
        IS_PENDING
    } irq_state_t;

    localparam logic [1:0] A_SAMPLE = 2'd0;
    localparam logic [1:0] A_STATUS = 2'd1;
    localparam logic [1:0] A_CTRL   = 2'd2;
    localparam logic [1:0] A_WMARK  = 2'd3;

    localparam int ST_HALF_BIT = 8;
    localparam int ST_LOW_BIT  = 9;
    localparam int ST_OVF_BIT  = 10;
    localparam int ST_IRQ_BIT  = 11;

    localparam int CTRL_IRQ_CLR_BIT = 0;
    localparam int CTRL_OVF_CLR_BIT = 1;

endpackage

// File: rtl/aud_rate_timer.sv
module aud_rate_timer #(
    parameter int CLK_HZ  = 125_000_000,
    parameter int RATE_HZ = 8000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int DIV = CLK_HZ / RATE_HZ;
    localparam int CW  = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    // R3
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R3
    tick_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == '0));

endmodule

// File: rtl/aud_sample_fifo.sv
module aud_sample_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    parameter int OCC_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic [W-1:0]     push_data,
    input  logic             pop_req,
    output logic             push_acc,
    output logic             pop_acc,
    output logic [W-1:0]     head,
    output logic [OCC_W-1:0] occ
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0]    PTR_LAST = PW'(DEPTH - 1);
    localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    assign pop_acc  = pop_req && (occ != '0);
    assign push_acc = push_req && ((occ != FULL_OCC) || pop_acc);
    assign head     = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_acc)
            mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push_acc)
                wr_ptr <= bump(wr_ptr);
            if (pop_acc)
                rd_ptr <= bump(rd_ptr);
            if (push_acc && !pop_acc)
                occ <= occ + 1'b1;
            else if (pop_acc && !push_acc)
                occ <= occ - 1'b1;
        end
    end

    // R2
    push_count_chk: assert property (@(posedge clk) disable iff (rst)
        (push_acc && !pop_acc) |=> (occ == $past(occ) + OCC_W'(1)));

    // R4
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (occ == FULL_OCC && push_req && !pop_req) |=> $stable(occ));

endmodule

// File: rtl/aud_bitrev_pwm.sv
module aud_bitrev_pwm #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level,
    output logic         pwm
);
    logic [W-1:0] ramp;
    logic [W-1:0] ramp_rev;

    always_ff @(posedge clk) begin
        if (rst)
            ramp <= '0;
        else
            ramp <= ramp + 1'b1;
    end

    generate
        for (genvar i = 0; i < W; i++) begin : g_rev
            assign ramp_rev[i] = ramp[W-1-i];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            pwm <= 1'b0;
        else
            pwm <= (ramp_rev < level);
    end

    // R8
    pwm_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (level == '0) |=> !pwm);

endmodule

// File: rtl/aud_play_ctrl.sv
module aud_play_ctrl
    import aud_fifo_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    parameter int OCC_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [OCC_W-1:0] occ,
    input  logic [W-1:0]     head,
    input  logic             push_acc,
    input  logic             pop_acc,
    input  logic             irq_clr,
    output logic             pop_req,
    output logic [W-1:0]     held,
    output logic             irq_pending
);
    localparam logic [W-1:0]     SILENCE = {1'b1, {(W-1){1'b0}}};
    localparam logic [OCC_W-1:0] HALF_UP = OCC_W'(DEPTH / 2 + 1);

    play_state_t ps_q, ps_d;
    irq_state_t  is_q, is_d;
    logic        empty;
    logic        drain_cross;
    logic [W-1:0] smp_q;

    assign empty       = (occ == '0);
    assign drain_cross = pop_acc && !push_acc && (occ == HALF_UP);

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_q <= PS_SILENT;
            is_q <= IS_ARMED;
        end else begin
            ps_q <= ps_d;
            is_q <= is_d;
        end
    end

    always_comb begin
        ps_d = ps_q;
        unique case (ps_q)
            PS_SILENT:  if (tick && !empty) ps_d = PS_PLAYING;
            PS_PLAYING: if (tick && empty)  ps_d = PS_SILENT;
            default:    ps_d = PS_SILENT;
        endcase
        is_d = is_q;
        unique case (is_q)
            IS_ARMED:   if (drain_cross)             is_d = IS_PENDING;
            IS_PENDING: if (irq_clr && !drain_cross) is_d = IS_ARMED;
            default:    is_d = IS_ARMED;
        endcase
    end

    always_comb begin
        pop_req     = tick && !empty;
        held        = (ps_q == PS_PLAYING) ? smp_q : SILENCE;
        irq_pending = (is_q == IS_PENDING);
    end

    always_ff @(posedge clk) begin
        if (rst)
            smp_q <= SILENCE;
        else if (pop_acc)
            smp_q <= head;
    end

    // R5
    irq_set_chk: assert property (@(posedge clk) disable iff (rst)
        drain_cross |=> irq_pending);

    // R5
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_pending && !irq_clr) |=> irq_pending);

    // R7
    silence_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && empty) |=> (held == SILENCE));

endmodule

// File: rtl/aud_fifo_out.sv
module aud_fifo_out
    import aud_fifo_pkg::*;
#(
    parameter int CLK_HZ   = 125_000_000,
    parameter int RATE_HZ  = 8000,
    parameter int DEPTH    = 16,
    parameter int SAMPLE_W = 8,
    parameter int RD_W     = 16,
    parameter int WM_RESET = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [1:0]          bus_addr,
    input  logic [SAMPLE_W-1:0] bus_wdata,
    output logic [RD_W-1:0]     bus_rdata,
    output logic                irq,
    output logic                dma_req,
    output logic                audio_out
);
    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam logic [OCC_W-1:0] HALF = OCC_W'(DEPTH / 2);

    logic                tick;
    logic                push_req;
    logic                push_acc;
    logic                pop_req;
    logic                pop_acc;
    logic [SAMPLE_W-1:0] head;
    logic [SAMPLE_W-1:0] held;
    logic [OCC_W-1:0]    occ;
    logic [OCC_W-1:0]    wmark;
    logic                ovf_q;
    logic                ovf_clr;
    logic                irq_clr;
    logic                irq_pending;
    logic [RD_W-1:0]     status_w;

    assign push_req = bus_wr && (bus_addr == A_SAMPLE);
    assign irq_clr  = bus_wr && (bus_addr == A_CTRL) && bus_wdata[CTRL_IRQ_CLR_BIT];
    assign ovf_clr  = bus_wr && (bus_addr == A_CTRL) && bus_wdata[CTRL_OVF_CLR_BIT];

    aud_rate_timer #(
        .CLK_HZ (CLK_HZ),
        .RATE_HZ(RATE_HZ)
    ) u_timer (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    aud_sample_fifo #(
        .DEPTH(DEPTH),
        .W    (SAMPLE_W),
        .OCC_W(OCC_W)
    ) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push_req (push_req),
        .push_data(bus_wdata),
        .pop_req  (pop_req),
        .push_acc (push_acc),
        .pop_acc  (pop_acc),
        .head     (head),
        .occ      (occ)
    );

    aud_play_ctrl #(
        .W    (SAMPLE_W),
        .DEPTH(DEPTH),
        .OCC_W(OCC_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .occ        (occ),
        .head       (head),
        .push_acc   (push_acc),
        .pop_acc    (pop_acc),
        .irq_clr    (irq_clr),
        .pop_req    (pop_req),
        .held       (held),
        .irq_pending(irq_pending)
    );

    aud_bitrev_pwm #(
        .W(SAMPLE_W)
    ) u_pwm (
        .clk  (clk),
        .rst  (rst),
        .level(held),
        .pwm  (audio_out)
    );

    always_ff @(posedge clk) begin
        if (rst)
            wmark <= OCC_W'(WM_RESET);
        else if (bus_wr && (bus_addr == A_WMARK))
            wmark <= bus_wdata[OCC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            ovf_q <= 1'b0;
        else if (push_req && !push_acc)
            ovf_q <= 1'b1;
        else if (ovf_clr)
            ovf_q <= 1'b0;
    end

    assign dma_req = (occ < wmark);
    assign irq     = irq_pending;

    always_comb begin
        status_w              = '0;
        status_w[OCC_W-1:0]   = occ;
        status_w[ST_HALF_BIT] = (occ <= HALF);
        status_w[ST_LOW_BIT]  = dma_req;
        status_w[ST_OVF_BIT]  = ovf_q;
        status_w[ST_IRQ_BIT]  = irq_pending;
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_rd) begin
            unique case (bus_addr)
                A_STATUS: bus_rdata <= status_w;
                A_WMARK:  bus_rdata <= RD_W'(wmark);
                default:  bus_rdata <= '0;
            endcase
        end
    end

    // R4
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !ovf_clr) |=> ovf_q);

    // R4
    ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_q) |-> $past(push_req));

endmodule

// File: tb/aud_fifo_out_tb.sv
module aud_fifo_out_tb;
    localparam int CLK_HZ  = 4_096_000;
    localparam int RATE_HZ = 8000;
    localparam int DIV     = CLK_HZ / RATE_HZ;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic        bus_rd;
    logic [1:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic [15:0] bus_rdata;
    logic        irq;
    logic        dma_req;
    logic        audio_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int tick_ref = 0;
    int wm_m = 4;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    aud_fifo_out #(.CLK_HZ(CLK_HZ), .RATE_HZ(RATE_HZ)) u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .dma_req(dma_req), .audio_out(audio_out)
    );

    function automatic int exp_status(int occ, int wm, int ovf, int irqp);
        return occ | (int'(occ <= 8) << 8) | (int'(occ < wm) << 9) | (ovf << 10) | (irqp << 11);
    endfunction

    function automatic int exp_ones(int lvl);
        return lvl;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input int a, input int d);
        bus_wr = 1'b1; bus_addr = 2'(a); bus_wdata = 8'(d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int a, output int v);
        bus_rd = 1'b1; bus_addr = 2'(a);
        @(negedge clk);
        bus_rd = 1'b0;
        v = int'(bus_rdata);
    endtask

    task automatic poll_occ(input int target);
        int v;
        bus_read(1, v);
        while ((v & 31) != target) bus_read(1, v);
    endtask

    task automatic wait_pop();
        int prev;
        int cur;
        bus_rd = 1'b1; bus_addr = 2'd1;
        @(negedge clk);
        prev = int'(bus_rdata[4:0]);
        @(negedge clk);
        cur = int'(bus_rdata[4:0]);
        while (cur >= prev) begin
            prev = cur;
            @(negedge clk);
            cur = int'(bus_rdata[4:0]);
        end
        bus_rd = 1'b0;
        tick_ref = cyc - 1;
    endtask

    task automatic wait_until_tick();
        while (cyc != tick_ref + DIV - 1) @(negedge clk);
    endtask

    task automatic count_ones(output int n);
        n = 0;
        repeat (256) begin
            @(negedge clk);
            n += int'(audio_out);
        end
    endtask

    task automatic count_toggles(output int n);
        logic prev;
        n = 0;
        prev = audio_out;
        repeat (64) begin
            @(negedge clk);
            if (audio_out != prev) n++;
            prev = audio_out;
        end
    endtask

    task automatic level_test(input int lvl);
        int n;
        poll_occ(0);
        repeat (4) bus_write(0, lvl);
        poll_occ(2);
        count_ones(n);
        chk("R8 duty", n, exp_ones(lvl));
    endtask

    initial begin
        wait (cyc >= 150000);
        if (!done) begin
            errors++;
            $display("FAIL R3 watchdog act=%0d exp=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        int a;
        int n;
        void'($urandom(32'd2024));
        rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq", int'(irq), 0);
        chk("R1 dma_req", int'(dma_req), 1);
        bus_read(1, v); chk("R1 status", v, exp_status(0, 4, 0, 0));
        bus_read(3, v); chk("R1 watermark", v, 4);
        count_toggles(n); chk("R1 silence toggles", n, 64);

        // R2 pushes and status layout
        bus_write(0, 8'h10); bus_write(0, 8'h20); bus_write(0, 8'h30);
        bus_read(1, v); chk("R2 status", v, exp_status(3, wm_m, 0, 0));
        chk("R6 dma_req high", int'(dma_req), 1);

        // R6 watermark
        bus_write(3, 2); wm_m = 2;
        chk("R6 dma_req low", int'(dma_req), 0);
        bus_read(3, v); chk("R6 watermark readback", v, 2);
        bus_read(1, v); chk("R6 status", v, exp_status(3, wm_m, 0, 0));

        // R3 removal rate
        repeat (5) bus_write(0, 8'h44);
        bus_read(1, a);
        repeat (3 * DIV - 1) @(negedge clk);
        bus_read(1, v);
        chk("R3 pops in three periods", (a & 31) - (v & 31), 3);

        // R9 order
        poll_occ(0);
        repeat (3) bus_write(0, 8'h30);
        repeat (3) bus_write(0, 8'hD0);
        poll_occ(4); count_ones(n); chk("R9 first sample", n, 8'h30);
        poll_occ(1); count_ones(n); chk("R9 second sample", n, 8'hD0);

        // R8 directed extremes and random levels
        level_test(0);
        level_test(255);
        for (int i = 0; i < 5; i++) level_test(int'($urandom % 256));

        // R7 silence after starving
        poll_occ(0);
        repeat (DIV + 2) @(negedge clk);
        count_ones(n); chk("R7 silence duty", n, 128);
        count_toggles(n); chk("R7 silence toggles", n, 64);

        // R5 clear in the same edge as the 9 -> 8 crossing
        chk("R5 idle irq", int'(irq), 0);
        bus_write(0, 8'h55);
        wait_pop();
        repeat (9) bus_write(0, 8'h66);
        bus_write(3, 10); wm_m = 10;
        chk("R6 dma at 9 below 10", int'(dma_req), 1);
        bus_write(3, 9); wm_m = 9;
        chk("R6 dma at 9 vs 9", int'(dma_req), 0);
        wait_until_tick();
        bus_write(2, 1);
        chk("R5 set wins over clear", int'(irq), 1);
        bus_read(1, v); chk("R5 status pending", v, exp_status(8, wm_m, 0, 1));
        bus_write(2, 1);
        chk("R5 cleared", int'(irq), 0);
        repeat (DIV + 4) @(negedge clk);
        chk("R5 no re-raise below half", int'(irq), 0);

        // R4 full FIFO, drop, sticky flag, push in removal edge
        poll_occ(0);
        bus_write(0, 8'h77);
        wait_pop();
        for (int i = 0; i < 16; i++) bus_write(0, i);
        bus_write(0, 8'hEE);
        bus_read(1, v); chk("R4 overflow set", v, exp_status(16, wm_m, 1, 0));
        bus_write(2, 2);
        wait_until_tick();
        bus_write(0, 8'h11);
        bus_read(1, v); chk("R4 push during removal", v, exp_status(16, wm_m, 0, 0));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule